// File: doc/BRIEF.md
# Twelve-Bit Reloading Up-Counter with Overflow and Match Interrupts

The block is a free-running 12-bit up-counter for timebase and periodic-event work. On every counting step it advances by one. When it steps past its top code 0xFFF it does not return to zero. It restarts from a value that software has placed in a reload register, and it raises an overflow flag. A separate 12-bit match register raises a match flag when the counter steps onto that value. Each flag has its own enable, and the single interrupt line is the OR of the enabled flags.

The counting rate comes from a 2-bit source selector. One setting stops the counter. The other three each pick one of three single-cycle enable strobes on the system clock: a slow timebase, a CPU-rate strobe and a fast strobe. Software reaches the block through a byte-wide port with address, write strobe, read strobe, write data and combinational read data. Reads have side effects, and these take place at the clock edge on which the read strobe is sampled.

Top module: `reload_timer12`

## Requirements
- R1: After reset, every register location (addresses 0 to 6) reads 0x00 and `irq` is low.
- R2: Source select `csr[4:3]` works as follows: 00 means no counting, 01 counts `slow_tick`, 10 counts `cpu_tick` and 11 counts `fast_tick`. Each strobe cycle of the selected source advances the count by exactly one. Strobes from the sources that are not selected have no effect.
- R3: A counting step taken while the counter holds 0xFFF loads the reload register value into the counter instead of zero.
- R4: That 0xFFF-to-reload step sets the overflow flag, which reads at `csr[2]`.
- R5: A read of address 0 returns both flags and then clears them. If a flag-setting event falls on the same edge as the read, the flag ends up set.
- R6: The match flag (`csr[5]`) is set by the step that makes the counter equal the match register, which is held at addresses 5 (bits 11:8 in the low nibble) and 6 (bits 7:0).
- R7: `irq` = (`csr[2]` AND `csr[1]`) OR (`csr[5]` AND `csr[0]`). It stays high until the flags are cleared or the enables are removed.
- R8: Address 1 returns {4'b0, count[11:8]} and latches count[7:0] as it does so. Address 2 returns that latched byte, which gives a coherent 12-bit snapshot.
- R9: The reload register (address 3 holds bits 11:8 in its low nibble, address 4 holds bits 7:0) reads back what was written. A write to it leaves the running count unchanged and is used at the next overflow.
- R10: Writes to address 0 store bits 4:3, 1 and 0. Bits 2 and 5 are status bits and software cannot write them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | Slow timebase enable strobe |
| cpu_tick | input | 1 | CPU-rate enable strobe |
| fast_tick | input | 1 | Fast enable strobe |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects at the clock edge) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives the counter past 0xFFF with a nonzero reload value. A design that wraps to zero, or that takes the value written mid-run straight into the count, shows the wrong count right after the wrap. It reads the high counter byte, lets the counter advance, and then reads the low byte, so a design without the latch returns a torn value. It also lands a match event on the same edge as a status read to confirm that the flag survives. It toggles the enables while a flag is pending to show that `irq` follows the masking and is not an edge pulse.

// File: rtl/timer12_pkg.sv
// Shared encodings for the 12-bit reloading timer.
// Assumes a byte-wide register port with a 3-bit address.
package timer12_pkg;
    typedef enum logic [1:0] {
        CS_OFF  = 2'b00,
        CS_SLOW = 2'b01,
        CS_CPU  = 2'b10,
        CS_FAST = 2'b11
    } clk_sel_e;

    localparam logic [2:0] A_CSR  = 3'd0;
    localparam logic [2:0] A_CNTH = 3'd1;
    localparam logic [2:0] A_CNTL = 3'd2;
    localparam logic [2:0] A_RLDH = 3'd3;
    localparam logic [2:0] A_RLDL = 3'd4;
    localparam logic [2:0] A_CMPH = 3'd5;
    localparam logic [2:0] A_CMPL = 3'd6;

    localparam int B_CMPIE = 0;
    localparam int B_OVFIE = 1;
    localparam int B_OVF   = 2;
    localparam int B_SEL   = 3;
    localparam int B_CMPF  = 5;
endpackage

// File: rtl/timer12_clksel.sv
// Counting-source selector: turns the 2-bit select and three strobes into
// a single counting step. Assumes strobes are one system-clock cycle wide.
module timer12_clksel
    import timer12_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  clk_sel_e   sel,
    input  logic       slow_tick,
    input  logic       cpu_tick,
    input  logic       fast_tick,
    output logic       tick
);
    localparam int NSRC = 3;

    logic [NSRC:1] src;
    logic [NSRC:1] hit;

    assign src = {fast_tick, cpu_tick, slow_tick};

    // One comparator per source; code 0 has no source and so never counts.
    for (genvar i = 1; i <= NSRC; i++) begin : g_src
        assign hit[i] = (sel == clk_sel_e'(i)) && src[i];
    end

    assign tick = |hit;

    p_off_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CS_OFF) |-> !tick);
    p_step_single_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/timer12_core.sv
// Counter datapath: counts up on each step, reloads past the top code and
// emits one-cycle overflow and match events. Assumes reload and match
// values are stable registers owned by the register block.
module timer12_core #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             cmp_evt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic             at_top;
    logic [CNT_W-1:0] next_cnt;

    // Next value: reload past the top code, otherwise increment.
    always_comb begin
        at_top   = (cnt == TOP);
        next_cnt = at_top ? reload_val : cnt + CNT_W'(1);
    end

    assign ovf_evt = tick && at_top;
    assign cmp_evt = tick && (next_cnt == cmp_val);

    // Counter register, advanced only on a counting step.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= next_cnt;
    end

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    p_step_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != TOP) |=> cnt == $past(cnt) + CNT_W'(1));
    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == TOP) |=> cnt == $past(reload_val));
endmodule

// File: rtl/timer12_regs.sv
// Register file: control/status, counter snapshot, reload and match
// registers, sticky flags and the interrupt. Assumes CNT_W is 9..16 so the
// count splits into one high and one low byte.
module timer12_regs
    import timer12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf_evt,
    input  logic             cmp_evt,
    output logic [7:0]       rdata,
    output clk_sel_e         sel,
    output logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cmp_val,
    output logic             irq
);
    localparam int HI_W = CNT_W - 8;

    logic       ovf_ie, cmp_ie, ovf_flag, cmp_flag;
    logic [7:0] snap_lo;
    logic       csr_rd, csr_wr;

    assign csr_rd = rd_en && (addr == A_CSR);
    assign csr_wr = wr_en && (addr == A_CSR);

    // Software-writable control and value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel        <= CS_OFF;
            ovf_ie     <= 1'b0;
            cmp_ie     <= 1'b0;
            reload_val <= '0;
            cmp_val    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CSR: begin
                    sel    <= clk_sel_e'(wdata[B_SEL+1:B_SEL]);
                    ovf_ie <= wdata[B_OVFIE];
                    cmp_ie <= wdata[B_CMPIE];
                end
                A_RLDH: reload_val[CNT_W-1:8] <= wdata[HI_W-1:0];
                A_RLDL: reload_val[7:0]       <= wdata;
                A_CMPH: cmp_val[CNT_W-1:8]    <= wdata[HI_W-1:0];
                A_CMPL: cmp_val[7:0]          <= wdata;
                default: ;
            endcase
        end
    end

    // Sticky flags: hardware set beats a status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt || (ovf_flag && !csr_rd);
            cmp_flag <= cmp_evt || (cmp_flag && !csr_rd);
        end
    end

    // Low-byte snapshot, captured when the high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                           snap_lo <= '0;
        else if (rd_en && addr == A_CNTH)     snap_lo <= cnt[7:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CSR: begin
                rdata[B_SEL+1:B_SEL] = sel;
                rdata[B_OVFIE]       = ovf_ie;
                rdata[B_CMPIE]       = cmp_ie;
                rdata[B_OVF]         = ovf_flag;
                rdata[B_CMPF]        = cmp_flag;
            end
            A_CNTH: rdata = {{(8-HI_W){1'b0}}, cnt[CNT_W-1:8]};
            A_CNTL: rdata = snap_lo;
            A_RLDH: rdata = {{(8-HI_W){1'b0}}, reload_val[CNT_W-1:8]};
            A_RLDL: rdata = reload_val[7:0];
            A_CMPH: rdata = {{(8-HI_W){1'b0}}, cmp_val[CNT_W-1:8]};
            A_CMPL: rdata = cmp_val[7:0];
            default: rdata = '0;
        endcase
    end

    // Level interrupt from the enabled flags.
    assign irq = (ovf_flag && ovf_ie) || (cmp_flag && cmp_ie);

    p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
    p_cmp_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> cmp_flag);
    p_rd_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && !ovf_evt && !cmp_evt) |=> (!ovf_flag && !cmp_flag));
    p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !csr_rd && !csr_wr) |=> irq);
endmodule

// File: rtl/reload_timer12.sv
// Top level of the 12-bit reloading timer: source selector, counter core
// and register file. Assumes all strobes are synchronous to clk.
module reload_timer12
    import timer12_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       cpu_tick,
    input  logic       fast_tick,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    clk_sel_e         sel;
    logic             tick, ovf_evt, cmp_evt;
    logic [CNT_W-1:0] cnt, reload_val, cmp_val;

    timer12_clksel u_clksel (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .slow_tick(slow_tick), .cpu_tick(cpu_tick), .fast_tick(fast_tick),
        .tick(tick)
    );

    timer12_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .reload_val(reload_val), .cmp_val(cmp_val),
        .cnt(cnt), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
    );

    timer12_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .cnt(cnt), .ovf_evt(ovf_evt), .cmp_evt(cmp_evt),
        .rdata(rdata), .sel(sel), .reload_val(reload_val), .cmp_val(cmp_val),
        .irq(irq)
    );

    p_rst_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && cnt == '0));
endmodule

// File: tb/reload_timer12_bench.sv
`timescale 1ns/1ps
module reload_timer12_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0, cpu_tick = 1'b0, fast_tick = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    reload_timer12 u_reload_timer12 (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cpu_tick(cpu_tick),
        .fast_tick(fast_tick), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        rd(a, d);
        check(d == exp, tag, d, exp);
    endtask

    task automatic cnt_chk(input int exp, input string tag);
        logic [7:0] h, l;
        rd(3'd1, h);
        rd(3'd2, l);
        check({h, l} == exp[15:0], tag, {h, l}, exp);
    endtask

    // which: 1 slow, 2 cpu, 3 fast; strobe held for n edges
    task automatic pulse(input int which, input int n);
        @(negedge clk);
        slow_tick = (which == 1); cpu_tick = (which == 2); fast_tick = (which == 3);
        repeat (n) @(negedge clk);
        slow_tick = 1'b0; cpu_tick = 1'b0; fast_tick = 1'b0;
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        @(negedge clk); #1 check(irq == exp, tag, irq, exp);
    endtask

    task automatic t_reset;
        for (int a = 0; a < 7; a++) rd_chk(3'(a), 8'h00, "R1 reset register");
        irq_chk(1'b0, "R1 reset irq");
    endtask

    task automatic t_off;
        pulse(1, 5); pulse(2, 5); pulse(3, 5);
        cnt_chk(0, "R2 select off holds count");
    endtask

    task automatic t_sources;
        wr(3'd0, 8'h08);
        pulse(1, 3); pulse(2, 4); pulse(3, 5);
        cnt_chk(3, "R2 slow source only");
        wr(3'd0, 8'h10);
        pulse(2, 7); pulse(1, 2); pulse(3, 2);
        cnt_chk(10, "R2 cpu source only");
        wr(3'd0, 8'hFF);
        rd_chk(3'd0, 8'h1B, "R10 csr writable bits only");
        wr(3'd0, 8'h18);
        pulse(3, 6); pulse(1, 2); pulse(2, 2);
        cnt_chk(16, "R2 fast source only");
    endtask

    task automatic t_snapshot;
        logic [7:0] h, l;
        pulse(3, 16'h2F0);
        rd(3'd1, h);
        check(h == 8'h03, "R8 high byte", h, 8'h03);
        pulse(3, 16'h20);
        rd(3'd2, l);
        check(l == 8'h00, "R8 low byte is latched", l, 8'h00);
        cnt_chk(16'h0320, "R8 fresh snapshot");
    endtask

    task automatic t_reload_write;
        wr(3'd3, 8'hF0);
        wr(3'd4, 8'hA5);
        cnt_chk(16'h0320, "R9 reload write leaves count");
        rd_chk(3'd3, 8'h00, "R9 reload high readback");
        rd_chk(3'd4, 8'hA5, "R9 reload low readback");
    endtask

    task automatic t_overflow;
        pulse(3, 12'hFFF - 12'h320);
        cnt_chk(16'h0FFF, "R3 reached top");
        rd_chk(3'd0, 8'h18, "R4 no flag before wrap");
        pulse(3, 1);
        cnt_chk(16'h00A5, "R3 wrap loads reload value");
        rd_chk(3'd0, 8'h1C, "R4 overflow flag set");
        rd_chk(3'd0, 8'h18, "R5 status read clears flag");
    endtask

    task automatic t_compare;
        wr(3'd5, 8'h00);
        wr(3'd6, 8'hB0);
        pulse(3, 8'h0A);
        rd_chk(3'd0, 8'h18, "R6 no match yet");
        pulse(3, 1);
        rd_chk(3'd0, 8'h38, "R6 match flag set");
        rd_chk(3'd0, 8'h18, "R5 match flag cleared");
    endtask

    task automatic t_irq;
        wr(3'd0, 8'h1A);
        pulse(3, 12'hFFF - 12'h0B0 + 1);
        irq_chk(1'b1, "R7 overflow irq");
        wr(3'd0, 8'h18);
        irq_chk(1'b0, "R7 masked overflow irq");
        wr(3'd0, 8'h1A);
        irq_chk(1'b1, "R7 unmasked pending overflow");
        rd_chk(3'd0, 8'h1E, "R5 status before clear");
        irq_chk(1'b0, "R7 irq drops after clear");
        wr(3'd0, 8'h19);
        pulse(3, 8'h0B);
        irq_chk(1'b1, "R7 match irq");
        rd_chk(3'd0, 8'h39, "R6 match flag for irq");
        irq_chk(1'b0, "R7 match irq cleared");
    endtask

    task automatic t_set_wins;
        wr(3'd6, 8'hB1);
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1; fast_tick = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; fast_tick = 1'b0;
        rd_chk(3'd0, 8'h39, "R5 set wins over read clear");
        irq_chk(1'b0, "R5 cleared after second read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_off();
        t_sources();
        t_snapshot();
        t_reload_write();
        t_overflow();
        t_compare();
        t_irq();
        t_set_wins();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule